// File: doc/BRIEF.md
# Block Address Translator

This block maps a 32-bit logical address onto a physical address through a small set of programmable block descriptors. Each descriptor covers a naturally aligned, power-of-two region. It holds a tag, a mask that selects the bits forming the block number, a physical base, two access-enable bits and a two-bit protection code. The block keeps two independent descriptor sets, one for instruction fetch and one for data access. A select input picks which set a lookup uses, and a separate select picks which set a descriptor write goes to.

The lookup is combinational from the address, the privilege level and the set select. It returns a hit flag, the protection code of the winning descriptor and the physical address. When an access is presented with its valid strobe and the winning descriptor's protection forbids it, a storage fault is registered. The fault carries a syndrome word and the offending logical address. Descriptor writes are synchronous and take effect on the following cycle.

Top module: `bat_xlate`

## Requirements
- R1: Synchronous reset clears every descriptor in both sets, so every lookup misses. It also clears `flt_valid`, `flt_syndrome` and `flt_addr` to zero.
- R2: A descriptor is eligible only when its enable field has the bit for the requester's level set. Field bit 1 enables supervisor access (`acc_user`=0) and field bit 0 enables user access (`acc_user`=1).
- R3: An eligible descriptor matches when `acc_addr & mask == tag`. When several descriptors match, the one with the lowest index supplies the result.
- R4: On a hit, `paddr` equals the descriptor's physical base ORed with the logical address bits outside its mask, and `prot_out` equals its protection code.
- R5: On a miss, `hit`, `prot_out` and `paddr` are all zero, and no fault is raised.
- R6: `acc_side`=0 looks up the instruction set and `acc_side`=1 looks up the data set. `cfg_side` selects the set for writes with the same encoding. The two sets never affect each other.
- R7: A valid access that hits a descriptor with protection code 2'b00 faults, whether it is a read or a write. The syndrome is 32'h0800_0000, with bit 25 also set when `acc_write` is 1.
- R8: A protection code with bit 0 set faults on writes only. Code 2'b10 never faults.
- R9: A fault sets `flt_valid` for exactly the one cycle after the faulting access. `flt_syndrome` and `flt_addr` are loaded at that edge and hold their value until the next fault.
- R10: No fault is raised while `acc_valid` is 0, whatever the address.
- R11: A descriptor write with `cfg_we`=1 changes only the addressed entry of the addressed set. Lookups see the new entry from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_side | input | 1 | Set for the write: 0 instruction, 1 data |
| cfg_idx | input | 2 | Descriptor index to write |
| cfg_tag | input | 32 | Block tag (already masked) |
| cfg_mask | input | 32 | Block-number mask |
| cfg_pbase | input | 32 | Physical base of the block |
| cfg_en | input | 2 | Access enables: bit 1 supervisor, bit 0 user |
| cfg_prot | input | 2 | Protection code |
| acc_valid | input | 1 | Access strobe that qualifies fault reporting |
| acc_side | input | 1 | Set for the lookup: 0 instruction, 1 data |
| acc_addr | input | 32 | Logical address |
| acc_user | input | 1 | 1 for user level, 0 for supervisor |
| acc_write | input | 1 | 1 for a store |
| hit | output | 1 | Lookup hit |
| prot_out | output | 2 | Protection code of the winning descriptor |
| paddr | output | 32 | Translated physical address |
| flt_valid | output | 1 | One-cycle fault strobe |
| flt_syndrome | output | 32 | Fault syndrome word |
| flt_addr | output | 32 | Faulting logical address |

## Verification
A corrupted descriptor or a wrong priority choice shows up in the same cycle as the access, as a wrong `hit`, `prot_out` or `paddr`, because the lookup has no register on its path. A wrong fault decision shows one clock later, as a missing or extra `flt_valid` pulse, or as a syndrome or captured address that disagrees with the access before it. The stimulus deliberately stacks overlapping descriptors, mixes privilege levels on entries with only one enable, and reuses the same address across both sets. This exposes an inverted enable bit, a reversed search order or crosstalk between the sets.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PROT_W = 2;
  localparam int unsigned EN_W   = 2;

  localparam logic [ADDR_W-1:0] SYN_PROT  = 32'h0800_0000;
  localparam int unsigned       SYN_STORE = 25;

  typedef struct packed {
    logic [ADDR_W-1:0] tag;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] pbase;
    logic [EN_W-1:0]   en;    // [1] supervisor, [0] user
    logic [PROT_W-1:0] prot;
  } bat_entry_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned NUM_SET = 2,
  localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int unsigned SET_W  = (NUM_SET > 1) ? $clog2(NUM_SET) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SET_W-1:0]         wr_set,
  input  logic [IDX_W-1:0]         wr_idx,
  input  bat_entry_t               wr_entry,
  input  logic [SET_W-1:0]         rd_set,
  output bat_entry_t [NUM_ENT-1:0] rd_ents
);
  bat_entry_t [NUM_ENT-1:0] set_q [NUM_SET];

  for (genvar s = 0; s < NUM_SET; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        set_q[s] <= '0;
      end else if (we && (wr_set == SET_W'(s))) begin
        set_q[s][wr_idx] <= wr_entry;
      end
    end
  end

  always_comb begin
    rd_ents = set_q[0];
    for (int s = 1; s < NUM_SET; s++) begin
      if (rd_set == SET_W'(s)) rd_ents = set_q[s];
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4
) (
  input  bat_entry_t [NUM_ENT-1:0] ents,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     user,
  output logic                     hit,
  output logic [PROT_W-1:0]        prot,
  output logic [ADDR_W-1:0]        paddr
);
  logic [EN_W-1:0]    req_mask;
  logic [NUM_ENT-1:0] match;

  assign req_mask = {~user, user};

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign match[i] = (|(ents[i].en & req_mask)) &&
                      ((addr & ents[i].mask) == ents[i].tag);
  end

  // walk from the top so the lowest index is applied last and wins
  always_comb begin
    hit   = 1'b0;
    prot  = '0;
    paddr = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        prot  = ents[i].prot;
        paddr = ents[i].pbase | (addr & ~ents[i].mask);
      end
    end
  end
endmodule

// File: rtl/bat_fault.sv
module bat_fault
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              hit,
  input  logic [PROT_W-1:0] prot,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_syndrome,
  output logic [ADDR_W-1:0] flt_addr
);
  logic deny;
  logic [ADDR_W-1:0] syn_d;

  assign deny = valid && hit && ((prot == '0) || (prot[0] && write));

  always_comb begin
    syn_d = SYN_PROT;
    syn_d[SYN_STORE] = write;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid    <= 1'b0;
      flt_syndrome <= '0;
      flt_addr     <= '0;
    end else begin
      flt_valid <= deny;
      if (deny) begin
        flt_syndrome <= syn_d;
        flt_addr     <= addr;
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_side,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_tag,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic [ADDR_W-1:0] cfg_pbase,
  input  logic [EN_W-1:0]   cfg_en,
  input  logic [PROT_W-1:0] cfg_prot,
  input  logic              acc_valid,
  input  logic              acc_side,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_user,
  input  logic              acc_write,
  output logic              hit,
  output logic [PROT_W-1:0] prot_out,
  output logic [ADDR_W-1:0] paddr,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_syndrome,
  output logic [ADDR_W-1:0] flt_addr
);
  bat_entry_t               wr_entry;
  bat_entry_t [NUM_ENT-1:0] cur_ents;

  assign wr_entry = '{tag: cfg_tag, mask: cfg_mask, pbase: cfg_pbase,
                      en: cfg_en, prot: cfg_prot};

  bat_regfile #(.NUM_ENT(NUM_ENT), .NUM_SET(2)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wr_set   (cfg_side),
    .wr_idx   (cfg_idx),
    .wr_entry (wr_entry),
    .rd_set   (acc_side),
    .rd_ents  (cur_ents)
  );

  bat_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ents  (cur_ents),
    .addr  (acc_addr),
    .user  (acc_user),
    .hit   (hit),
    .prot  (prot_out),
    .paddr (paddr)
  );

  bat_fault u_fault (
    .clk          (clk),
    .rst          (rst),
    .valid        (acc_valid),
    .hit          (hit),
    .prot         (prot_out),
    .write        (acc_write),
    .addr         (acc_addr),
    .flt_valid    (flt_valid),
    .flt_syndrome (flt_syndrome),
    .flt_addr     (flt_addr)
  );
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              hit,
  input logic [PROT_W-1:0] prot_out,
  input logic [ADDR_W-1:0] paddr,
  input logic              flt_valid,
  input logic [ADDR_W-1:0] flt_syndrome,
  input logic [ADDR_W-1:0] flt_addr
);
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (paddr == '0 && prot_out == '0));

  p_fault_source_r9: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> $past(acc_valid && hit));

  p_idle_no_fault_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !flt_valid);

  p_syndrome_r7: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> ((flt_syndrome & ~32'h0200_0000) == SYN_PROT &&
                   flt_syndrome[SYN_STORE] == $past(acc_write)));

  p_fault_addr_r9: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> flt_addr == $past(acc_addr));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flt_valid |-> ($stable(flt_addr) && $stable(flt_syndrome)));

  p_read_only_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !$past(acc_write)) |-> $past(prot_out) == 2'b00);
endmodule

bind bat_xlate bat_xlate_chk u_chk (.*);

// File: tb/tb_bat_xlate.sv
`timescale 1ns/1ps
module tb_bat_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_side = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_tag = '0, cfg_mask = '0, cfg_pbase = '0;
  logic [1:0]  cfg_en = '0, cfg_prot = '0;
  logic        acc_valid = 1'b0, acc_side = 1'b0, acc_user = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        hit, flt_valid;
  logic [1:0]  prot_out;
  logic [31:0] paddr, flt_syndrome, flt_addr;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_tag [2][4];
  logic [31:0] m_mask[2][4];
  logic [31:0] m_pb  [2][4];
  logic [1:0]  m_en  [2][4];
  logic [1:0]  m_prot[2][4];
  logic [31:0] e_syn = '0, e_faddr = '0;

  always #2.5 clk = ~clk;

  bat_xlate dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_look(input bit s, input logic [31:0] a, input bit u,
                                   output bit h, output logic [1:0] p, output logic [31:0] pa);
    h = 0; p = '0; pa = '0;
    for (int i = 3; i >= 0; i--) begin
      if ((m_en[s][i] & (u ? 2'b01 : 2'b10)) != 2'b00 && (a & m_mask[s][i]) == m_tag[s][i]) begin
        h = 1; p = m_prot[s][i]; pa = m_pb[s][i] | (a & ~m_mask[s][i]);
      end
    end
  endfunction

  task automatic wr(input bit s, input int i, input logic [31:0] t, input logic [31:0] m,
                    input logic [31:0] pb, input logic [1:0] en, input logic [1:0] pr);
    @(negedge clk);
    cfg_we = 1; cfg_side = s; cfg_idx = 2'(i);
    cfg_tag = t; cfg_mask = m; cfg_pbase = pb; cfg_en = en; cfg_prot = pr;
    @(posedge clk); #1;
    cfg_we = 0;
    m_tag[s][i] = t; m_mask[s][i] = m; m_pb[s][i] = pb; m_en[s][i] = en; m_prot[s][i] = pr;
  endtask

  task automatic look(input bit s, input logic [31:0] a, input bit u, input bit w,
                      input bit v, input string req);
    bit h; logic [1:0] p; logic [31:0] pa; bit ef;
    @(negedge clk);
    acc_side = s; acc_addr = a; acc_user = u; acc_write = w; acc_valid = v;
    ref_look(s, a, u, h, p, pa);
    #1;
    chk({req, " hit"}, 32'(hit), 32'(h));
    chk({req, " prot"}, 32'(prot_out), 32'(p));
    chk({req, " paddr"}, paddr, pa);
    ef = v && h && (p == 2'b00 || (p[0] && w));
    if (ef) begin
      e_syn = 32'h0800_0000 | (w ? 32'h0200_0000 : 32'h0);
      e_faddr = a;
    end
    @(posedge clk); #1;
    acc_valid = 0;
    chk({req, " R9 flt_valid"}, 32'(flt_valid), 32'(ef));
    chk({req, " R7 syndrome"}, flt_syndrome, e_syn);
    chk({req, " R9 flt_addr"}, flt_addr, e_faddr);
  endtask

  task automatic rand_entry(input bit s, input int i);
    int k; logic [31:0] m;
    k = 17 + int'($urandom % 12);
    m = 32'hFFFF_FFFF << k;
    wr(s, i, $urandom & m, $urandom & m, m, 2'($urandom), 2'($urandom));
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) begin
        m_tag[s][i] = '0; m_mask[s][i] = '0; m_pb[s][i] = '0; m_en[s][i] = '0; m_prot[s][i] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk("R1 flt_valid", 32'(flt_valid), 0);
    chk("R1 syndrome", flt_syndrome, 0);
    chk("R1 flt_addr", flt_addr, 0);
    look(0, 32'h0000_0000, 0, 0, 1, "R1 cleared");
    look(1, 32'h1234_5678, 1, 1, 1, "R1 cleared");

    // R3 priority: entries 0 and 2 cover the same block
    wr(1, 2, 32'h4000_0000, 32'hF000_0000, 32'hA000_0000, 2'b11, 2'b10);
    wr(1, 0, 32'h4000_0000, 32'hF000_0000, 32'h9000_0000, 2'b01, 2'b10);
    look(1, 32'h4123_4567, 1, 0, 1, "R3 lowest wins");
    chk("R3 paddr", paddr, 32'h9123_4567);
    // R2: entry 0 is user-only, supervisor falls through to entry 2
    look(1, 32'h4123_4567, 0, 0, 1, "R2 sup skips user-only");
    chk("R2 paddr", paddr, 32'hA123_4567);
    // R4: finer mask
    wr(1, 1, 32'h8002_0000, 32'hFFFE_0000, 32'h0004_0000, 2'b10, 2'b10);
    look(1, 32'h8003_ABCD, 0, 1, 1, "R4 compose");
    chk("R4 paddr", paddr, 32'h0005_ABCD);
    // R5: miss
    look(1, 32'h7000_0000, 0, 1, 1, "R5 miss");
    chk("R5 hit", 32'(hit), 0);
    // R6: instruction set empty for same address
    look(0, 32'h4123_4567, 1, 0, 1, "R6 other set");
    chk("R6 hit", 32'(hit), 0);

    // R7: prot 00 faults on read and write
    wr(0, 3, 32'hC000_0000, 32'hE000_0000, 32'h2000_0000, 2'b11, 2'b00);
    look(0, 32'hC000_1000, 0, 0, 1, "R7 read");
    chk("R7 read syn", flt_syndrome, 32'h0800_0000);
    look(0, 32'hC000_2000, 1, 1, 1, "R7 write");
    chk("R7 write syn", flt_syndrome, 32'h0A00_0000);
    // R9 hold after pulse
    look(1, 32'h7000_0000, 0, 0, 1, "R9 hold");
    chk("R9 held addr", flt_addr, 32'hC000_2000);
    // R8: prot x1 faults on write only, 10 never
    wr(0, 0, 32'hE000_0000, 32'hE000_0000, 32'h0, 2'b11, 2'b01);
    look(0, 32'hE000_0004, 0, 0, 1, "R8 read ok");
    look(0, 32'hE000_0008, 0, 1, 1, "R8 write faults");
    look(1, 32'h4000_0010, 1, 1, 1, "R8 prot10 write ok");
    // R10: no fault without strobe
    look(0, 32'hC000_3000, 0, 1, 0, "R10 idle");
    chk("R10 flt_valid", 32'(flt_valid), 0);
    // R11: write data entry 1 only; instruction entry 3 unchanged
    wr(1, 1, 32'h0000_0000, 32'hF000_0000, 32'h5000_0000, 2'b11, 2'b10);
    look(1, 32'h0ABC_0000, 0, 0, 1, "R11 new entry");
    chk("R11 paddr", paddr, 32'h5ABC_0000);
    look(0, 32'hC000_0000, 0, 0, 1, "R11 other set intact");
    look(1, 32'h4000_0000, 1, 0, 1, "R11 neighbour intact");

    // random mix
    for (int r = 0; r < 400; r++) begin
      bit s; int e;
      if (r % 50 == 0)
        for (int s2 = 0; s2 < 2; s2++)
          for (int i = 0; i < 4; i++) rand_entry(s2[0], i);
      s = 1'($urandom);
      e = int'($urandom % 4);
      if ($urandom % 4 != 0)
        look(s, m_tag[s][e] | ($urandom & ~m_mask[s][e]), 1'($urandom), 1'($urandom),
             1'($urandom % 8 != 0), "R2 R3 R4 R6 random");
      else
        look(s, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R5 R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule